// File: doc/BRIEF.md
# PCI Interrupt Mask and Summary Controller

This block gathers nineteen level-sensitive PCI interrupt sources and combines them into a single interrupt request for the processor. A host reaches the block through three adjacent byte-wide ports on a small ISA-style I/O bus. Writing a port loads eight per-source mask bits. Reading a port does not return the mask. It returns the synchronized raw levels of the sources, so software can see which device is asserting even when that source is masked. A mask bit of 1 blocks its source. The request output is high while at least one unmasked source is asserted.

The sources enter as one packed vector. Source index i appears in port i/8 at bit i%8. The index order is: slot lines A0..A3 (0..3), the legacy bridge cascade (4), IDE (5), USB (6), slot line B0 (7), B1..B3 (8..10), C0..C3 (11..14), D0 (15), and D1..D3 (16..18). The cascade source gets no special treatment and is masked like every other source. The inputs come from outside the clock domain and pass through a synchronizer before they are used.

Top module: `pci_irq_summary`

## Requirements
- R1: On reset every mask bit is 1, `irq_req` is 0, `bus_rdata_en` is 0 and `bus_rdata` is 0.
- R2: The ports sit at `BASE_ADDR` (0x804), `BASE_ADDR+1` and `BASE_ADDR+2`. Source index i is reported and masked at bit i%8 of port i/8.
- R3: When a write strobe hits a port, the data byte replaces that port's mask bits in the same cycle. A 1 blocks the source and a 0 enables it. While all mask bits are 1, `irq_req` stays 0.
- R4: A read strobe to a port gives, on the next cycle, `bus_rdata_en`=1 and that port's synchronized raw source levels on `bus_rdata`. The mask has no effect on the value read.
- R5: Bits 7..3 of port `BASE_ADDR+2` always read 0. Writes to those bits are ignored, and the bits never raise `irq_req`.
- R6: `irq_req` is registered. It follows a mask write one cycle later. A raw input change reaches it after the two synchronizer stages plus one cycle, which is three clock edges in total.
- R7: Sources are level-sensitive. `irq_req` stays high for as long as an unmasked source is held high, and it drops once that source goes low.
- R8: Reads and writes to any other address are ignored. They change no mask bit, and they leave `bus_rdata_en` at 0 and `bus_rdata` at 0.
- R9: The cascade source (index 4, port 0 bit 4) is enabled and blocked by its own mask bit, in the same way as any other source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 19 | Raw level interrupt sources, packed in index order |
| bus_addr | input | 12 | I/O address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| bus_rdata_en | output | 1 | High while `bus_rdata` carries data for a decoded read |
| irq_req | output | 1 | Combined interrupt request |

## Verification
The assertions check the following on every cycle:
- the reset values;
- that a decoded read strobe, and only a decoded one, raises `bus_rdata_en` one cycle later;
- that `bus_rdata` stays quiet when not enabled;
- that the reserved bits read zero;
- that a fully masked bank or a quiet synchronized input never produces a request.

The bench scenarios are needed for the rest:
- the interleaved bit placement;
- the exact three-edge input latency and one-edge mask latency;
- readback of raw levels while the sources are masked;
- the cascade bit's masking;
- the evidence that writes to foreign addresses left the mask untouched.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // Number of byte ports needed to cover n sources.
    function automatic int ports_for(input int n);
        return (n + BYTE_W - 1) / BYTE_W;
    endfunction

endpackage

// File: rtl/pirq_sync.sv
// Multi-stage synchronizer for a vector of level signals.
module pirq_sync #(
    parameter int W      = 19,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= stage_d[s];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/pirq_decode.sv
// Maps a bus address onto one of NUM_PORTS consecutive byte ports.
module pirq_decode #(
    parameter int                NUM_PORTS = 3,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h804,
    localparam int               IDX_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic                 hit,
    output logic [IDX_W-1:0]     idx,
    output logic [NUM_PORTS-1:0] sel
);

    logic [ADDR_W-1:0] offset;

    assign offset = addr - BASE_ADDR;
    assign hit    = offset < ADDR_W'(NUM_PORTS);
    assign idx    = offset[IDX_W-1:0];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_sel
        assign sel[p] = (offset == ADDR_W'(p));
    end

endmodule

// File: rtl/pirq_mask_bank.sv
// Write-only mask storage and registered request combining.
module pirq_mask_bank
    import pirq_pkg::*;
#(
    parameter int  NUM_SRC   = 19,
    localparam int NUM_PORTS = ports_for(NUM_SRC),
    localparam int TOTAL_W   = NUM_PORTS * BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [NUM_PORTS-1:0] wr_sel,
    input  byte_t                wdata,
    input  logic [NUM_SRC-1:0]   lines,
    output logic [NUM_SRC-1:0]   mask,
    output logic                 req
);

    typedef struct packed {
        logic [TOTAL_W-1:0] mask;
        logic               req;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [TOTAL_W-1:0] lines_wide;

    always_comb begin
        lines_wide              = '0;
        lines_wide[NUM_SRC-1:0] = lines;

        bank_d     = bank_q;
        bank_d.req = |(lines_wide & ~bank_q.mask);

        for (int p = 0; p < NUM_PORTS; p++) begin
            if (wr_en && wr_sel[p]) begin
                bank_d.mask[p*BYTE_W +: BYTE_W] = wdata;
            end
        end
        // Bits past the last source stay blocked whatever is written.
        for (int i = NUM_SRC; i < TOTAL_W; i++) begin
            bank_d.mask[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q.mask <= '1;
            bank_q.req  <= 1'b0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign mask = bank_q.mask[NUM_SRC-1:0];
    assign req  = bank_q.req;

endmodule

// File: rtl/pci_irq_summary.sv
module pci_irq_summary
    import pirq_pkg::*;
#(
    parameter int                NUM_SRC     = 19,
    parameter int                ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 'h804,
    parameter int                SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_lines,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [7:0]         bus_wdata,
    input  logic               bus_wr,
    input  logic               bus_rd,
    output logic [7:0]         bus_rdata,
    output logic               bus_rdata_en,
    output logic               irq_req
);

    localparam int NUM_PORTS = ports_for(NUM_SRC);
    localparam int TOTAL_W   = NUM_PORTS * BYTE_W;
    localparam int IDX_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    typedef struct packed {
        byte_t rdata;
        logic  rden;
    } rd_t;

    logic [NUM_SRC-1:0]   sync_lines;
    logic [NUM_SRC-1:0]   mask_q;
    logic                 port_hit;
    logic [IDX_W-1:0]     port_idx;
    logic [NUM_PORTS-1:0] port_sel;
    logic [TOTAL_W-1:0]   status_wide;
    rd_t                  rd_d, rd_q;

    pirq_sync #(
        .W      (NUM_SRC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (irq_lines),
        .dout  (sync_lines)
    );

    pirq_decode #(
        .NUM_PORTS (NUM_PORTS),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .addr (bus_addr),
        .hit  (port_hit),
        .idx  (port_idx),
        .sel  (port_sel)
    );

    pirq_mask_bank #(
        .NUM_SRC (NUM_SRC)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr & port_hit),
        .wr_sel (port_sel),
        .wdata  (bus_wdata),
        .lines  (sync_lines),
        .mask   (mask_q),
        .req    (irq_req)
    );

    // Readback: the raw synchronized levels, never the mask.
    always_comb begin
        status_wide              = '0;
        status_wide[NUM_SRC-1:0] = sync_lines;
        rd_d = '0;
        if (bus_rd && port_hit) begin
            rd_d.rden  = 1'b1;
            rd_d.rdata = status_wide[int'(port_idx)*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign bus_rdata    = rd_q.rdata;
    assign bus_rdata_en = rd_q.rden;

endmodule

// File: rtl/pirq_summary_checker.sv
module pirq_summary_checker #(
    parameter int                NUM_SRC   = 19,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h804
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_rd,
    input logic [7:0]         bus_rdata,
    input logic               bus_rdata_en,
    input logic               irq_req,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [NUM_SRC-1:0] sync_lines
);

    localparam int NPORT  = (NUM_SRC + 7) / 8;
    localparam int RES_LO = NUM_SRC - (NPORT - 1) * 8;
    localparam logic [ADDR_W-1:0] LAST_ADDR = BASE_ADDR + ADDR_W'(NPORT - 1);

    logic in_rng;
    assign in_rng = (bus_addr >= BASE_ADDR) && (bus_addr <= LAST_ADDR);

    // R1: reset leaves everything blocked and quiet
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> ((&mask_q) && !irq_req && !bus_rdata_en));

    // R3: a fully blocked bank never requests
    p_all_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |=> !irq_req);

    // R4: a decoded read strobe yields data on the next cycle
    p_read_data_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && in_rng) |=> bus_rdata_en);

    // R8: no foreign or absent read produces data
    p_no_stray_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && in_rng) |=> !bus_rdata_en);

    p_quiet_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdata_en |-> (bus_rdata == 8'h00));

    // R6: a request needs some synchronized line on the prior cycle
    p_req_needs_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(|sync_lines));

    if (RES_LO < 8) begin : g_res
        // R5: reserved positions of the last port read as zero
        p_reserved_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && bus_addr == LAST_ADDR) |=> (bus_rdata[7:RES_LO] == '0));
    end

endmodule

bind pci_irq_summary pirq_summary_checker #(
    .NUM_SRC   (NUM_SRC),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_rd       (bus_rd),
    .bus_rdata    (bus_rdata),
    .bus_rdata_en (bus_rdata_en),
    .irq_req      (irq_req),
    .mask_q       (mask_q),
    .sync_lines   (sync_lines)
);

// File: tb/test_pci_irq_summary.sv
module test_pci_irq_summary;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [18:0] irq_lines = '0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        bus_rdata_en;
    logic        irq_req;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] data;
        logic       en;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk = ~clk;

    pci_irq_summary i_pci_irq_summary (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_lines    (irq_lines),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_rdata    (bus_rdata),
        .bus_rdata_en (bus_rdata_en),
        .irq_req      (irq_req)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [7:0] d,
                            input logic en, input string tag);
        exp_t e;
        @(negedge clk);
        e.data = d;
        e.en   = en;
        e.tag  = tag;
        exp_q.push_back(e);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic set_lines(input logic [18:0] v);
        @(negedge clk);
        irq_lines = v;
    endtask

    task automatic check_req(input logic exp, input string tag);
        n_checks++;
        if (irq_req !== exp) begin
            n_errors++;
            $display("FAIL %s irq_req actual %0b expected %0b", tag, irq_req, exp);
        end
    endtask

    // Monitor: compares each read result against the scoreboard.
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd) begin
                @(negedge clk);
                n_checks++;
                if (exp_q.size() == 0) begin
                    n_errors++;
                    $display("FAIL R4 read with empty scoreboard");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (bus_rdata !== e.data || bus_rdata_en !== e.en) begin
                        n_errors++;
                        $display("FAIL %s rdata/en actual %02h/%0b expected %02h/%0b",
                                 e.tag, bus_rdata, bus_rdata_en, e.data, e.en);
                    end
                end
            end
        end
    end

    initial begin
        wait_cyc(3);
        // R1: reset values
        n_checks++;
        if (irq_req !== 1'b0 || bus_rdata_en !== 1'b0 || bus_rdata !== 8'h00) begin
            n_errors++;
            $display("FAIL R1 reset req/en/data actual %0b/%0b/%02h expected 0/0/00",
                     irq_req, bus_rdata_en, bus_rdata);
        end
        rst_n = 1'b1;

        // R1 / R3: all blocked after reset
        set_lines(19'h7FFFF);
        wait_cyc(5);
        check_req(1'b0, "R1 masked after reset");

        // R4 / R5: raw levels read back while masked
        bus_read(12'h804, 8'hFF, 1'b1, "R4 port0 all high");
        bus_read(12'h805, 8'hFF, 1'b1, "R4 port1 all high");
        bus_read(12'h806, 8'h07, 1'b1, "R5 port2 reserved zero");

        // R2: distinct pattern per port
        set_lines({3'b101, 8'h96, 8'hC3});
        wait_cyc(4);
        bus_read(12'h804, 8'hC3, 1'b1, "R2 port0 pattern");
        bus_read(12'h805, 8'h96, 1'b1, "R2 port1 pattern");
        bus_read(12'h806, 8'h05, 1'b1, "R2 port2 pattern");

        // R6: mask write reaches request one cycle later
        bus_write(12'h806, 8'h00);
        check_req(1'b0, "R6 mask latency before");
        wait_cyc(1);
        check_req(1'b1, "R6 mask latency after");

        // R3: re-blocking clears the request
        bus_write(12'h806, 8'hFF);
        wait_cyc(1);
        check_req(1'b0, "R3 reblock");

        // R5: reserved write bits ignored, real bits enabled
        bus_write(12'h806, 8'hF8);
        wait_cyc(1);
        check_req(1'b1, "R5 reserved write ignored");

        // R7: level removed drops the request
        set_lines({3'b000, 8'h96, 8'hC3});
        wait_cyc(4);
        check_req(1'b0, "R7 level removed");
        bus_read(12'h806, 8'h00, 1'b1, "R4 port2 after drop");
        bus_write(12'h806, 8'hFF);

        // R9: cascade source masked individually
        set_lines(19'h00010);
        wait_cyc(4);
        check_req(1'b0, "R9 cascade blocked");
        bus_write(12'h804, 8'hEF);
        wait_cyc(1);
        check_req(1'b1, "R9 cascade enabled");
        bus_write(12'h804, 8'h10);
        wait_cyc(1);
        check_req(1'b0, "R9 cascade reblocked");

        // R6: input latency of three edges
        set_lines(19'h00011);
        wait_cyc(2);
        check_req(1'b0, "R6 input latency early");
        wait_cyc(1);
        check_req(1'b1, "R6 input latency due");

        // R8: foreign addresses leave mask unchanged
        bus_write(12'h804, 8'hFF);
        wait_cyc(1);
        check_req(1'b0, "R8 setup");
        bus_write(12'h807, 8'h00);
        bus_write(12'h803, 8'h00);
        bus_write(12'hC04, 8'h00);
        wait_cyc(2);
        check_req(1'b0, "R8 foreign writes ignored");
        bus_read(12'h807, 8'h00, 1'b0, "R8 foreign read above");
        bus_read(12'h803, 8'h00, 1'b0, "R8 foreign read below");
        bus_read(12'h804, 8'h11, 1'b1, "R4 port0 after foreign");

        // R2 / R7: port1 mask bit position and held level
        bus_write(12'h805, 8'hFE);
        set_lines(19'h00100);
        wait_cyc(4);
        check_req(1'b1, "R2 port1 bit0 enabled");
        wait_cyc(10);
        check_req(1'b1, "R7 level held");
        set_lines(19'h00200);
        wait_cyc(4);
        check_req(1'b0, "R2 port1 bit1 blocked");

        wait_cyc(3);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule